// File: doc/BRIEF.md
# Receive Runt Filter Gate

This block sits on the receive side of an Ethernet MAC, between the incoming byte stream and the receive DMA engine. For every frame it decides in which byte the DMA engine may start moving data, and at the frame's last byte it reports whether the frame is kept or thrown away. Two start rules exist. In the first, DMA starts once the frame's byte count reaches a programmable watermark. In the second, DMA starts only once a frame has reached the 64-byte legal minimum, and a frame that ends shorter than that is discarded. The second rule is used only when the runt-reject bit is set and the link is running full-duplex.

The block also holds a three-bit configuration register: a full-duplex enable, the runt-reject bit and a duplex enable for the attachment-unit port. It resolves the active duplex mode from that register, the selected port and a link-test-disable override. Only a hard reset clears the register. A soft reset or a stop command leaves it as it is, but abandons the frame in progress. The start rule and the watermark are captured at the first byte of a frame, so configuration traffic during a frame does not change how that frame is handled.

All three outputs are registered. A pulse caused by a byte is high in the cycle after the clock edge that samples that byte.

Top module: `rx_runt_gate`

## Requirements
- R1: While `rst` is high, and in the cycle after, `cfg_q` reads 0 and `dma_start`, `frame_keep`, `frame_drop` and `fd_active` are all low.
- R2: A cycle with `soft_rst` or `stop_cmd` high leaves `cfg_q` unchanged and abandons the frame in progress, so the next byte counts as byte 1 of a new frame.
- R3: `fd_active` (registered, one cycle behind the inputs) is high only when `cfg_q[0]` is 1 and one of these holds: `port_sel`=0 (twisted pair) with `link_test_dis` low, `port_sel`=1 (attachment unit) with `cfg_q[2]` at 1, or `port_sel`=2 (serial). `port_sel`=3 always gives half-duplex.
- R4: In watermark mode, `dma_start` pulses for the byte whose 1-based count within the frame equals `wmark`. A `wmark` of 0 behaves as 1.
- R5: In watermark mode, if a frame ends before its count reaches `wmark`, `dma_start` pulses for the last byte. Every frame in watermark mode ends with a `frame_keep` pulse.
- R6: Reject mode is in force when `cfg_q[1]` is 1 and full-duplex is active. In reject mode, `dma_start` pulses for byte 64 and never earlier, and a frame of 64 bytes or more ends with `frame_keep`.
- R7: In reject mode, a frame whose last byte comes before byte 64 ends with a one-cycle `frame_drop` pulse and has no `dma_start` pulse. `frame_keep` and `frame_drop` are never high together.
- R8: With `cfg_q[1]` at 1 but full-duplex inactive, the watermark rule of R4 and R5 applies.
- R9: `dma_start` pulses at most once per frame, and the byte count restarts at 1 for the byte after a last byte.
- R10: The start rule (reject mode or watermark) and the watermark are captured at a frame's first byte. Configuration writes or duplex changes made later in that frame take effect from the next frame.
- R11: When `cfg_wr` is high, `cfg_wdata` is loaded into `cfg_q` at the clock edge, with bit 0 the full-duplex enable, bit 1 runt reject and bit 2 the attachment-unit duplex enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hard reset, synchronous, active high; clears configuration and frame state |
| soft_rst | input | 1 | Soft reset; abandons the current frame, keeps configuration |
| stop_cmd | input | 1 | Stop command; same effect on the block as soft reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 3 | Configuration write data (bit 0 duplex enable, bit 1 runt reject, bit 2 attachment-unit duplex) |
| cfg_q | output | 3 | Configuration register contents |
| port_sel | input | 2 | Active network port: 0 twisted pair, 1 attachment unit, 2 serial, 3 reserved |
| link_test_dis | input | 1 | Link test disabled; forces the twisted-pair port to half-duplex |
| wmark | input | 16 | Receive watermark in bytes |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_last | input | 1 | The present byte ends the frame |
| dma_start | output | 1 | One-cycle request to start receive DMA for the current frame |
| frame_keep | output | 1 | One-cycle pulse: the frame that just ended is kept |
| frame_drop | output | 1 | One-cycle pulse: the frame that just ended is a runt and is dropped |
| fd_active | output | 1 | Resolved duplex mode, high for full-duplex |

## Verification
The bound checker watches, on every cycle, the properties that need no knowledge of the stimulus. It confirms that the configuration survives soft resets and stop commands and is zero after a hard reset. It confirms that a disabled duplex bit always gives half-duplex, that a dropped frame carries no DMA start, that keep and drop never coincide and always follow a last byte, and that no frame gets a second DMA start. Which byte actually triggers DMA, which frames are discarded, how the duplex cases resolve per port, and whether a mid-frame change waits for the next frame all depend on the whole history of the frame, so only the bench's frame scenarios can show them.

// File: rtl/rx_gate_pkg.sv
package rx_gate_pkg;

  // Network port selection codes (decoded by the duplex resolver)
  typedef enum logic [1:0] {
    PORT_TP   = 2'd0,
    PORT_AUI  = 2'd1,
    PORT_SER  = 2'd2,
    PORT_RSVD = 2'd3
  } port_e;

  // Configuration register layout: bit0 duplex enable, bit1 runt reject,
  // bit2 attachment-unit duplex enable
  typedef struct packed {
    logic aui_fd;
    logic runt_rej;
    logic fd_en;
  } gate_cfg_t;

  localparam int CFG_W = $bits(gate_cfg_t);

  // DMA start rule chosen for a frame
  typedef enum logic {
    TRIG_WMARK  = 1'b0,
    TRIG_MINLEN = 1'b1
  } trig_e;

endpackage

// File: rtl/rx_cfg_reg.sv
module rx_cfg_reg
  import rx_gate_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_en,
  input  gate_cfg_t wr_data,
  output gate_cfg_t cfg
);

  // Only the hard reset clears the register; soft reset and stop never reach it
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (wr_en) begin
      cfg <= wr_data;
    end
  end

endmodule

// File: rtl/rx_duplex_res.sv
module rx_duplex_res
  import rx_gate_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  gate_cfg_t cfg,
  input  logic [1:0] port_sel,
  input  logic      link_test_dis,
  output logic      fd_now,
  output logic      fd_q
);

  logic port_ok;

  always_comb begin
    case (port_e'(port_sel))
      PORT_TP:  port_ok = ~link_test_dis;
      PORT_AUI: port_ok = cfg.aui_fd;
      PORT_SER: port_ok = 1'b1;
      default:  port_ok = 1'b0;
    endcase
    fd_now = cfg.fd_en & port_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fd_q <= 1'b0;
    end else begin
      fd_q <= fd_now;
    end
  end

endmodule

// File: rtl/rx_len_track.sv
module rx_len_track
  import rx_gate_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int WM_W  = 16
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             abort,
  input  logic             rx_valid,
  input  logic             rx_last,
  input  logic             rej_now,
  input  logic [WM_W-1:0]  wm_now,
  output logic [CNT_W-1:0] cur_n,
  output trig_e            mode_eff,
  output logic [CNT_W-1:0] thr_eff
);

  logic [CNT_W-1:0] cnt_q;
  logic             in_frame_q;
  trig_e            mode_q;
  logic [CNT_W-1:0] thr_q;
  logic [CNT_W-1:0] thr_new;
  trig_e            mode_new;

  // Watermark of zero is promoted to one byte
  always_comb begin
    thr_new  = (wm_now == '0) ? CNT_W'(1) : CNT_W'(wm_now);
    mode_new = rej_now ? TRIG_MINLEN : TRIG_WMARK;
  end

  // Count including the present byte, saturating at the counter limit
  always_comb begin
    cur_n    = (cnt_q == '1) ? cnt_q : cnt_q + CNT_W'(1);
    mode_eff = in_frame_q ? mode_q : mode_new;
    thr_eff  = in_frame_q ? thr_q  : thr_new;
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      cnt_q      <= '0;
      in_frame_q <= 1'b0;
      mode_q     <= TRIG_WMARK;
      thr_q      <= CNT_W'(1);
    end else if (rx_valid) begin
      if (!in_frame_q) begin
        mode_q <= mode_new;
        thr_q  <= thr_new;
      end
      if (rx_last) begin
        cnt_q      <= '0;
        in_frame_q <= 1'b0;
      end else begin
        cnt_q      <= cur_n;
        in_frame_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rx_start_decide.sv
module rx_start_decide
  import rx_gate_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int MIN_LEN = 64
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             abort,
  input  logic             rx_valid,
  input  logic             rx_last,
  input  logic [CNT_W-1:0] cur_n,
  input  trig_e            mode,
  input  logic [CNT_W-1:0] thr,
  output logic             dma_start,
  output logic             frame_keep,
  output logic             frame_drop
);

  localparam logic [CNT_W-1:0] MIN_N = CNT_W'(MIN_LEN);

  logic started_q;
  logic hit;
  logic runt;

  always_comb begin
    if (mode == TRIG_MINLEN) begin
      hit  = (cur_n >= MIN_N);
      runt = rx_last && (cur_n < MIN_N);
    end else begin
      hit  = (cur_n >= thr) || rx_last;
      runt = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      started_q  <= 1'b0;
      dma_start  <= 1'b0;
      frame_keep <= 1'b0;
      frame_drop <= 1'b0;
    end else begin
      dma_start  <= rx_valid && !started_q && hit;
      frame_keep <= rx_valid && rx_last && !runt;
      frame_drop <= rx_valid && rx_last && runt;
      if (rx_valid) begin
        if (rx_last) begin
          started_q <= 1'b0;
        end else if (hit) begin
          started_q <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/rx_runt_gate.sv
module rx_runt_gate
  import rx_gate_pkg::*;
#(
  parameter int WM_W    = 16,
  parameter int MIN_LEN = 64
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            soft_rst,
  input  logic            stop_cmd,
  input  logic            cfg_wr,
  input  logic [2:0]      cfg_wdata,
  output logic [2:0]      cfg_q,
  input  logic [1:0]      port_sel,
  input  logic            link_test_dis,
  input  logic [WM_W-1:0] wmark,
  input  logic            rx_valid,
  input  logic            rx_last,
  output logic            dma_start,
  output logic            frame_keep,
  output logic            frame_drop,
  output logic            fd_active
);

  localparam int MIN_W = $clog2(MIN_LEN + 1);
  localparam int CNT_W = (WM_W > MIN_W) ? WM_W : MIN_W;

  gate_cfg_t        cfg;
  logic             fd_now;
  logic             abort;
  logic [CNT_W-1:0] cur_n;
  logic [CNT_W-1:0] thr_eff;
  trig_e            mode_eff;

  assign abort = soft_rst | stop_cmd;
  assign cfg_q = cfg;

  rx_cfg_reg u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_wr),
    .wr_data (gate_cfg_t'(cfg_wdata)),
    .cfg     (cfg)
  );

  rx_duplex_res u_dup (
    .clk           (clk),
    .rst           (rst),
    .cfg           (cfg),
    .port_sel      (port_sel),
    .link_test_dis (link_test_dis),
    .fd_now        (fd_now),
    .fd_q          (fd_active)
  );

  rx_len_track #(
    .CNT_W (CNT_W),
    .WM_W  (WM_W)
  ) u_len (
    .clk      (clk),
    .rst      (rst),
    .abort    (abort),
    .rx_valid (rx_valid),
    .rx_last  (rx_last),
    .rej_now  (cfg.runt_rej & fd_now),
    .wm_now   (wmark),
    .cur_n    (cur_n),
    .mode_eff (mode_eff),
    .thr_eff  (thr_eff)
  );

  rx_start_decide #(
    .CNT_W   (CNT_W),
    .MIN_LEN (MIN_LEN)
  ) u_dec (
    .clk        (clk),
    .rst        (rst),
    .abort      (abort),
    .rx_valid   (rx_valid),
    .rx_last    (rx_last),
    .cur_n      (cur_n),
    .mode       (mode_eff),
    .thr        (thr_eff),
    .dma_start  (dma_start),
    .frame_keep (frame_keep),
    .frame_drop (frame_drop)
  );

endmodule

// File: rtl/rx_runt_gate_chk.sv
module rx_runt_gate_chk (
  input logic       clk,
  input logic       rst,
  input logic       soft_rst,
  input logic       stop_cmd,
  input logic       cfg_wr,
  input logic [2:0] cfg_q,
  input logic       rx_valid,
  input logic       rx_last,
  input logic       dma_start,
  input logic       frame_keep,
  input logic       frame_drop,
  input logic       fd_active
);

  // Starts seen since the last frame end or abort
  logic start_seen_q;

  always_ff @(posedge clk) begin
    if (rst || soft_rst || stop_cmd || frame_keep || frame_drop) begin
      start_seen_q <= 1'b0;
    end else if (dma_start) begin
      start_seen_q <= 1'b1;
    end
  end

  // R1: hard reset leaves configuration and outputs cleared
  p_hard_clear_r1: assert property (@(posedge clk)
    rst |=> (cfg_q == 3'b000 && !dma_start && !frame_keep && !frame_drop && !fd_active));

  // R2: soft reset and stop keep the configuration
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (rst)
    ((soft_rst || stop_cmd) && !cfg_wr) |=> $stable(cfg_q));

  // R3: no duplex enable means half-duplex on the next cycle
  p_half_when_off_r3: assert property (@(posedge clk) disable iff (rst)
    !cfg_q[0] |=> !fd_active);

  // R7: a dropped frame carries no DMA start, and keep/drop exclude each other
  p_drop_no_start_r7: assert property (@(posedge clk) disable iff (rst)
    frame_drop |-> (!dma_start && !frame_keep));

  // R5: every frame outcome follows a last byte
  p_end_follows_last_r5: assert property (@(posedge clk) disable iff (rst)
    (frame_keep || frame_drop) |-> $past(rx_valid && rx_last));

  // R9: no second DMA start within one frame
  p_one_start_r9: assert property (@(posedge clk) disable iff (rst)
    dma_start |-> !start_seen_q);

endmodule

bind rx_runt_gate rx_runt_gate_chk u_chk (.*);

// File: tb/rx_runt_gate_tb.sv
`timescale 1ns/1ps
module rx_runt_gate_tb;

  typedef struct packed {
    logic [2:0]  cfg;
    logic [1:0]  port;
    logic        lts;
    logic [15:0] wm;
    logic [15:0] len;
    logic [15:0] idx;
    logic        drop;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{3'b010, 2'd0, 1'b0, 16'd10, 16'd20,  16'd10, 1'b0},
    '{3'b001, 2'd0, 1'b0, 16'd5,  16'd40,  16'd5,  1'b0},
    '{3'b011, 2'd0, 1'b0, 16'd5,  16'd100, 16'd64, 1'b0},
    '{3'b011, 2'd0, 1'b0, 16'd5,  16'd30,  16'd0,  1'b1},
    '{3'b011, 2'd0, 1'b0, 16'd5,  16'd64,  16'd64, 1'b0},
    '{3'b011, 2'd0, 1'b1, 16'd8,  16'd30,  16'd8,  1'b0},
    '{3'b011, 2'd1, 1'b0, 16'd3,  16'd20,  16'd3,  1'b0},
    '{3'b111, 2'd1, 1'b0, 16'd3,  16'd20,  16'd0,  1'b1},
    '{3'b011, 2'd2, 1'b0, 16'd3,  16'd63,  16'd0,  1'b1},
    '{3'b001, 2'd0, 1'b0, 16'd0,  16'd5,   16'd1,  1'b0},
    '{3'b001, 2'd0, 1'b0, 16'd50, 16'd12,  16'd12, 1'b0},
    '{3'b001, 2'd0, 1'b0, 16'd1,  16'd1,   16'd1,  1'b0},
    '{3'b011, 2'd0, 1'b0, 16'd9,  16'd1,   16'd0,  1'b1},
    '{3'b011, 2'd3, 1'b0, 16'd7,  16'd20,  16'd7,  1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        soft_rst = 1'b0;
  logic        stop_cmd = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_wdata = 3'b000;
  logic [2:0]  cfg_q;
  logic [1:0]  port_sel = 2'd0;
  logic        link_test_dis = 1'b0;
  logic [15:0] wmark = 16'd0;
  logic        rx_valid = 1'b0;
  logic        rx_last = 1'b0;
  logic        dma_start;
  logic        frame_keep;
  logic        frame_drop;
  logic        fd_active;

  int total = 0;
  int bad = 0;
  int got_idx;
  int got_cnt;
  int got_keep;
  int got_drop;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rx_runt_gate u_dut (
    .clk           (clk),
    .rst           (rst),
    .soft_rst      (soft_rst),
    .stop_cmd      (stop_cmd),
    .cfg_wr        (cfg_wr),
    .cfg_wdata     (cfg_wdata),
    .cfg_q         (cfg_q),
    .port_sel      (port_sel),
    .link_test_dis (link_test_dis),
    .wmark         (wmark),
    .rx_valid      (rx_valid),
    .rx_last       (rx_last),
    .dma_start     (dma_start),
    .frame_keep    (frame_keep),
    .frame_drop    (frame_drop),
    .fd_active     (fd_active)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit fd_exp(input logic [2:0] c, input logic [1:0] p, input logic l);
    if (!c[0]) return 1'b0;
    case (p)
      2'd0:    return !l;
      2'd1:    return c[2];
      2'd2:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input int k);
    case (k)
      0, 5, 6: return "R8";
      1, 9, 11: return "R4";
      2, 4: return "R6";
      3, 7, 8, 12: return "R7";
      10: return "R5";
      default: return "R3";
    endcase
  endfunction

  task automatic write_cfg(input logic [2:0] v);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Send len bytes; last flagged only when done is set; optional cfg write at byte cfg_at
  task automatic send_bytes(input int len, input bit done, input int cfg_at, input logic [2:0] cfg_v);
    got_idx = 0; got_cnt = 0; got_keep = 0; got_drop = 0;
    for (int i = 1; i <= len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_last = done && (i == len);
      cfg_wr = (i == cfg_at);
      cfg_wdata = cfg_v;
      @(posedge clk);
      #1;
      if (dma_start) begin
        got_cnt++;
        if (got_idx == 0) got_idx = i;
      end
      if (frame_keep) got_keep++;
      if (frame_drop) got_drop++;
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_last = 1'b0;
    cfg_wr = 1'b0;
  endtask

  task automatic pulse_abort(input bit use_stop);
    @(negedge clk);
    if (use_stop) stop_cmd = 1'b1; else soft_rst = 1'b1;
    @(negedge clk);
    stop_cmd = 1'b0;
    soft_rst = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk(cfg_q == 3'b000, "R1 cfg", cfg_q, 0);
    chk(!dma_start && !frame_keep && !frame_drop, "R1 pulses",
        {dma_start, frame_keep, frame_drop}, 0);
    chk(!fd_active, "R1 fd", fd_active, 0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    chk(cfg_q == 3'b000, "R1 cfg after release", cfg_q, 0);

    // R11: configuration write and layout
    write_cfg(3'b101);
    chk(cfg_q == 3'b101, "R11 write", cfg_q, 5);

    // Vector table of frames
    for (int k = 0; k < NV; k++) begin
      write_cfg(VECS[k].cfg);
      @(negedge clk);
      port_sel = VECS[k].port;
      link_test_dis = VECS[k].lts;
      wmark = VECS[k].wm;
      @(negedge clk);
      send_bytes(int'(VECS[k].len), 1'b1, 0, 3'b000);
      chk(got_idx == int'(VECS[k].idx), {tag_of(k), " dma byte"}, got_idx, int'(VECS[k].idx));
      chk(got_cnt == (VECS[k].drop ? 0 : 1), "R9 start count", got_cnt, VECS[k].drop ? 0 : 1);
      chk(got_drop == int'(VECS[k].drop) && got_keep == int'(!VECS[k].drop),
          {tag_of(k), " outcome"}, got_drop * 2 + got_keep, VECS[k].drop ? 2 : 1);
      chk(fd_active == fd_exp(VECS[k].cfg, VECS[k].port, VECS[k].lts),
          "R3 duplex", fd_active, fd_exp(VECS[k].cfg, VECS[k].port, VECS[k].lts));
    end

    // R2: soft reset keeps config and restarts the byte count
    @(negedge clk);
    port_sel = 2'd0; link_test_dis = 1'b0; wmark = 16'd5;
    write_cfg(3'b011);
    send_bytes(20, 1'b0, 0, 3'b000);
    pulse_abort(1'b0);
    chk(cfg_q == 3'b011, "R2 cfg after soft reset", cfg_q, 3);
    send_bytes(70, 1'b1, 0, 3'b000);
    chk(got_idx == 64, "R2 count restart after soft reset", got_idx, 64);
    send_bytes(30, 1'b0, 0, 3'b000);
    pulse_abort(1'b1);
    chk(cfg_q == 3'b011, "R2 cfg after stop", cfg_q, 3);
    send_bytes(64, 1'b1, 0, 3'b000);
    chk(got_idx == 64 && got_keep == 1, "R2 count restart after stop", got_idx, 64);

    // R9: back-to-back frames, count restarts after last byte
    send_bytes(10, 1'b1, 0, 3'b000);
    chk(got_drop == 1, "R9 first short frame dropped", got_drop, 1);
    send_bytes(64, 1'b1, 0, 3'b000);
    chk(got_idx == 64, "R9 next frame counts from 1", got_idx, 64);

    // R10: clearing the reject bit mid-frame does not rescue the frame
    send_bytes(30, 1'b1, 10, 3'b001);
    chk(got_cnt == 0 && got_drop == 1, "R10 mid-frame clear", got_drop, 1);
    send_bytes(20, 1'b1, 0, 3'b000);
    chk(got_idx == 5 && got_keep == 1, "R10 next frame uses watermark", got_idx, 5);
    // R10: setting the reject bit mid-frame keeps the watermark rule
    @(negedge clk);
    wmark = 16'd4;
    send_bytes(20, 1'b1, 2, 3'b011);
    chk(got_idx == 4 && got_keep == 1, "R10 mid-frame set", got_idx, 4);
    send_bytes(20, 1'b1, 0, 3'b000);
    chk(got_drop == 1 && got_cnt == 0, "R10 next frame rejects runt", got_drop, 1);

    // R1: hard reset clears configuration
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk(cfg_q == 3'b000, "R1 hard reset clears cfg", cfg_q, 0);
    @(negedge clk);
    rst = 1'b0;

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule